// File: doc/BRIEF.md
# Two-Bit Serial Register Bus Slave

This block is a register-access slave on a narrow serial bus. A master holds a request strobe high and, while it is high, sends two bits per clock on a two-bit input: first a command, then an address, then, for a write, the data byte. The slave turns these pairs back into parallel fields and accesses a small local file of 8-bit registers. It then answers with an acknowledge. A read also returns the addressed byte on a two-bit output.

The strobe length tells the two kinds of transfer apart. A read holds it for exactly 9 cycles and a write for exactly 11. Any other length, or a length that does not match the command bit, is treated as an aborted transfer and is dropped silently. Everything runs on one clock with a synchronous active-high reset. The register file has no reset: like a block RAM, it holds whatever was last written.

Frame layout, one pair per request cycle (cycle 1 is the first cycle the strobe is high):
- Cycle 1 is the command. Bit 1 = 1 means write and bit 1 = 0 means read. Bit 0 is reserved.
- Cycles 2..7 carry a 12-bit address, most significant pair first.
- For a write, cycles 8..11 carry the data byte, most significant pair first.
- For a read, the pairs in cycles 8..9 are ignored.

Top module: `sb2_slave`

## Requirements
- R1: A transfer is a read when the command pair has bit 1 = 0 and the strobe stays high for exactly 9 cycles. It is a write when bit 1 = 1 and the strobe stays high for exactly 11 cycles. Cycle 1 is the command, cycles 2..7 are the 12-bit address with the most significant pair first, and cycles 8..11 of a write are the data with the most significant pair first.
- R2: After a valid write to an implemented address, the register holds the sent byte. The acknowledge is high for exactly one cycle: the first cycle in which the strobe is low. The data output stays 2'b00 during that cycle.
- R3: After a valid read, the acknowledge is high for exactly 4 cycles, starting on the first cycle the strobe is low. During those cycles the data output carries the addressed byte, bits [7:6] first, then [5:4], [3:2] and [1:0].
- R4: Whenever the acknowledge is low, the data output is 2'b00.
- R5: If the strobe drops after any number of cycles other than 9 or 11, no acknowledge is given and no register changes.
- R6: A write command held for 9 cycles, or a read command held for 11 cycles, is discarded. No acknowledge is given and no register changes.
- R7: Implemented addresses are 0 to NREGS-1 (16 by default). A read of any higher address is acknowledged and returns 8'h00.
- R8: A write to an address at or above NREGS is acknowledged but changes no register. In particular, it does not alias onto a low address.
- R9: A request whose first cycle falls inside a read acknowledge is ignored in its entirety, even if the strobe stays high past the end of the acknowledge. A request that starts on the first cycle after the acknowledge ends is accepted.
- R10: After reset, the acknowledge is low and the data output is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe, held high for the length of a transfer |
| din_i | input | 2 | Serial command, address and write data, one pair per cycle |
| ack_o | output | 1 | Acknowledge: 1 cycle for a write, 4 cycles for a read |
| dout_o | output | 2 | Read data pairs, valid while ack_o is high, otherwise 0 |

## Verification
Every register is first written and then read back with a value computed from its address, so a wrong pair order or a wrong shift direction shows up as a mismatch. Addresses just above the implemented range and at the top of the 12-bit space check that reads return zero and that writes do not alias onto low registers. Strobe lengths on both sides of 9 and 11, and command bits that do not match the length, check that the slave decides by length and command together. A second request started in the last cycle of a read acknowledge must be dropped, while one started in the following cycle must be accepted; this tests the boundary of the busy window.

// File: rtl/sb2_pkg.sv
package sb2_pkg;

  // Frame geometry, fixed by the bus protocol
  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 8;
  localparam int ADDR_BEATS  = ADDR_W / 2;
  localparam int DATA_BEATS  = DATA_W / 2;
  localparam int RD_LEN      = 1 + ADDR_BEATS + 2;
  localparam int WR_LEN      = 1 + ADDR_BEATS + DATA_BEATS;
  localparam int CNT_W       = 4;

  // One decoded transfer as seen when the strobe drops
  typedef struct packed {
    logic              wr;
    logic              hit;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } xfer_t;

endpackage

// File: rtl/sb2_deser.sv
module sb2_deser
  import sb2_pkg::*;
#(
  parameter int NREGS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [1:0] din,
  input  logic       busy,
  output logic       done,
  output xfer_t      xfer
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] A_LAST  = CNT_W'(ADDR_BEATS);
  localparam logic [CNT_W-1:0] D_LAST  = CNT_W'(ADDR_BEATS + DATA_BEATS);
  localparam logic [CNT_W-1:0] RD_CNT  = CNT_W'(RD_LEN);
  localparam logic [CNT_W-1:0] WR_CNT  = CNT_W'(WR_LEN);

  logic              active;
  logic              blocked;
  logic              cmd_wr;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // Frame control: start, length count, block while a read answer is busy
  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      blocked <= 1'b0;
      cmd_wr  <= 1'b0;
      cnt     <= '0;
    end else if (active) begin
      if (req) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end else begin
        active <= 1'b0;
        cnt    <= '0;
      end
    end else if (blocked) begin
      if (!req) blocked <= 1'b0;
    end else if (req) begin
      if (busy) begin
        blocked <= 1'b1;
      end else begin
        active <= 1'b1;
        cnt    <= CNT_W'(1);
        cmd_wr <= din[1];
      end
    end
  end

  // Field shifters: address pairs then data pairs, most significant first
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (active && req) begin
      if (cnt <= A_LAST)
        addr_q <= {addr_q[ADDR_W-3:0], din};
      else if (cnt <= D_LAST)
        data_q <= {data_q[DATA_W-3:0], din};
    end
  end

  assign done = active && !req &&
                ((cmd_wr && cnt == WR_CNT) || (!cmd_wr && cnt == RD_CNT));

  assign xfer.wr   = cmd_wr;
  assign xfer.hit  = (int'(addr_q) < NREGS);
  assign xfer.addr = addr_q;
  assign xfer.data = data_q;

endmodule

// File: rtl/sb2_regfile.sv
module sb2_regfile #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Single write port, registered read port: block RAM shape
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sb2_ser.sv
module sb2_ser #(
  parameter int DATA_W  = 8,
  localparam int BEATS  = DATA_W / 2,
  localparam int LEFT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic              is_read,
  input  logic [DATA_W-1:0] rbyte,
  output logic              ack,
  output logic [1:0]        dout,
  output logic              busy
);

  logic [LEFT_W-1:0] left;
  logic [DATA_W-3:0] rest;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack  <= 1'b0;
      dout <= 2'b00;
      busy <= 1'b0;
      left <= '0;
      rest <= '0;
    end else if (done) begin
      ack <= 1'b1;
      if (is_read) begin
        dout <= rbyte[DATA_W-1 -: 2];
        rest <= rbyte[DATA_W-3:0];
        left <= LEFT_W'(BEATS - 1);
        busy <= 1'b1;
      end else begin
        dout <= 2'b00;
        left <= '0;
        busy <= 1'b0;
      end
    end else if (left != '0) begin
      ack  <= 1'b1;
      dout <= rest[DATA_W-3 -: 2];
      rest <= {rest[DATA_W-5:0], 2'b00};
      left <= left - 1'b1;
      busy <= 1'b1;
    end else begin
      ack  <= 1'b0;
      dout <= 2'b00;
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/sb2_slave.sv
module sb2_slave
  import sb2_pkg::*;
#(
  parameter int NREGS  = 16,
  localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic [1:0] din_i,
  output logic       ack_o,
  output logic [1:0] dout_o
);

  logic              done;
  logic              busy;
  xfer_t             xfer;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] rbyte;
  logic              we;

  sb2_deser #(.NREGS(NREGS)) u_deser (
    .clk  (clk),
    .rst  (rst),
    .req  (req_i),
    .din  (din_i),
    .busy (busy),
    .done (done),
    .xfer (xfer)
  );

  assign we = done && xfer.wr && xfer.hit;

  sb2_regfile #(.DEPTH(NREGS), .WIDTH(DATA_W)) u_regs (
    .clk   (clk),
    .we    (we),
    .waddr (xfer.addr[IDX_W-1:0]),
    .wdata (xfer.data),
    .raddr (xfer.addr[IDX_W-1:0]),
    .rdata (rdata)
  );

  assign rbyte = xfer.hit ? rdata : '0;

  sb2_ser #(.DATA_W(DATA_W)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .is_read (!xfer.wr),
    .rbyte   (rbyte),
    .ack     (ack_o),
    .dout    (dout_o),
    .busy    (busy)
  );

endmodule

// File: rtl/sb2_slave_chk.sv
module sb2_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       req,
  input logic       ack,
  input logic [1:0] dout
);

  logic [3:0] rlen;
  logic [3:0] last;
  logic [2:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rlen <= '0;
      last <= '0;
      run  <= '0;
    end else begin
      if (req) begin
        if (rlen != 4'hF) rlen <= rlen + 1'b1;
      end else begin
        rlen <= '0;
        if (rlen != '0) last <= rlen;
      end
      run <= ack ? ((run == 3'd7) ? run : run + 1'b1) : 3'd0;
    end
  end

  assert_dout_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !ack |-> dout == 2'b00) else $error("dout nonzero while ack low");

  assert_ack_after_drop_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> (!$past(req) && $past(req, 2))) else $error("ack not on first low cycle");

  assert_len_legal_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> (last == 4'd9 || last == 4'd11)) else $error("ack after illegal length");

  assert_ack_max_R3: assert property (@(posedge clk) disable iff (rst)
    ack |-> run <= 3'd3) else $error("ack longer than four cycles");

  assert_ack_shape_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> (run == 3'd1 || run == 3'd4)) else $error("ack run neither 1 nor 4");

  assert_write_ack_one_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack) && last == 4'd11) |=> !ack) else $error("write ack not single cycle");

  assert_read_ack_holds_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack) && last == 4'd9) |=> ack) else $error("read ack ended early");

endmodule

bind sb2_slave sb2_slave_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .req  (req_i),
  .ack  (ack_o),
  .dout (dout_o)
);

// File: tb/tb_sb2_slave.sv
`timescale 1ns/1ps
module tb_sb2_slave;

  localparam int NREGS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [1:0] din = 2'b00;
  logic       ack;
  logic [1:0] dout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sb2_slave #(.NREGS(NREGS)) dut (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req),
    .din_i  (din),
    .ack_o  (ack),
    .dout_o (dout)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R1: cycle 1 command, 2..7 address pairs, 8..11 data pairs, MSB first
  task automatic send(input bit wr, input int a, input logic [7:0] d, input int len);
    logic [11:0] av;
    av = 12'(a);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      req = 1'b1;
      if (k == 1)       din = {wr, 1'b0};
      else if (k <= 7)  din = av[11 - 2*(k-2) -: 2];
      else if (k <= 11) din = d[7 - 2*(k-8) -: 2];
      else              din = 2'b00;
    end
    @(negedge clk);
    req = 1'b0;
    din = 2'b00;
  endtask

  // Watch six cycles after the drop: ack count, first-cycle ack, byte, idle dout
  task automatic watch(output int nack, output bit first, output logic [7:0] b, output bit idle_ok);
    nack = 0; first = 1'b0; b = 8'h00; idle_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (ack) begin
        if (i == 0) first = 1'b1;
        nack++;
        b = {b[5:0], dout};
      end else if (dout != 2'b00) begin
        idle_ok = 1'b0;
      end
    end
  endtask

  task automatic do_write(input int a, input logic [7:0] d, input string tag);
    int n; bit f; logic [7:0] b; bit z;
    send(1'b1, a, d, 11);
    watch(n, f, b, z);
    chk(n == 1 && f, {tag, " write ack one cycle"}, n, 1);
    chk(b == 8'h00 && z, {tag, " dout zero on write/idle"}, int'(b), 0);
  endtask

  task automatic do_read(input int a, input logic [7:0] exp, input string tag);
    int n; bit f; logic [7:0] b; bit z;
    send(1'b0, a, 8'h00, 9);
    watch(n, f, b, z);
    chk(n == 4 && f, {tag, " read ack four cycles"}, n, 4);
    chk(b == exp, {tag, " read data"}, int'(b), int'(exp));
    chk(z, {tag, " dout zero while ack low"}, 0, 0);
  endtask

  task automatic expect_silent(input bit wr, input int a, input logic [7:0] d, input int len, input string tag);
    int n; bit f; logic [7:0] b; bit z;
    send(wr, a, d, len);
    watch(n, f, b, z);
    chk(n == 0, {tag, " no ack"}, n, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n; bit f; logic [7:0] b; bit z;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0 && dout == 2'b00, "R10 reset outputs", {ack, dout}, 0);

    // R1 R2 R3: sweep all registers
    for (int a = 0; a < NREGS; a++) do_write(a, pat(a), "R2");
    for (int a = 0; a < NREGS; a++) do_read(a, pat(a), "R3 R1");

    // R7: reads above the range
    do_read(NREGS, 8'h00, "R7 first out-of-range");
    do_read(12'hFFF, 8'h00, "R7 top address");
    do_read(12'h800, 8'h00, "R7 high bit");

    // R8: out-of-range writes acknowledged, no alias
    do_write(NREGS, 8'hAA, "R8 alias write");
    do_write(12'h800 | 3, 8'h55, "R8 high write");
    do_read(0, pat(0), "R8 reg0 kept");
    do_read(3, pat(3), "R8 reg3 kept");

    // R5: wrong lengths
    for (int len = 1; len <= 13; len++) begin
      if (len != 9 && len != 11) expect_silent(1'b1, 4, 8'hC3, len, "R5 bad length");
    end
    expect_silent(1'b0, 4, 8'h00, 8, "R5 short read");
    expect_silent(1'b0, 4, 8'h00, 10, "R5 long read");
    do_read(4, pat(4), "R5 reg4 kept");

    // R6: command and length mismatch
    expect_silent(1'b1, 2, 8'h3C, 9, "R6 write cmd len 9");
    expect_silent(1'b0, 2, 8'h3C, 11, "R6 read cmd len 11");
    do_read(2, pat(2), "R6 reg2 kept");

    // R9: request starting in the last read-ack cycle is dropped
    send(1'b0, 7, 8'h00, 9);
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(ack == 1'b1, "R9 in ack window", ack, 1);
    send(1'b1, 5, 8'h77, 11);
    watch(n, f, b, z);
    chk(n == 0, "R9 blocked request no ack", n, 0);
    do_read(5, pat(5), "R9 reg5 kept");

    // R9: request starting right after the ack window is accepted
    send(1'b0, 9, 8'h00, 9);
    n = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (ack) n++;
    end
    chk(n == 4, "R9 read ack before follow-up", n, 4);
    do_write(6, 8'h9E, "R9 follow-up accepted");
    do_read(6, 8'h9E, "R9 follow-up stored");

    // R2: new value overwrites, extremes
    do_write(NREGS - 1, 8'hFF, "R2 top reg");
    do_write(1, 8'h00, "R2 zero value");
    do_read(NREGS - 1, 8'hFF, "R2 top reg read");
    do_read(1, 8'h00, "R2 zero read");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule